// File: doc/BRIEF.md
# Per-Branch Local History Direction Predictor

This block predicts whether a conditional branch will be taken. It does so from the record of that same branch's recent outcomes. The front end presents a branch address on a lookup stream and receives a one-bit taken/not-taken prediction on a response stream. Later, the back end reports the resolved outcome of the branch on a resolve stream, and the block trains on it.

The table is addressed by a slice of the branch address and carries no tags, so unrelated branches that share an index share an entry. Each entry holds two things:
- a 4-bit record of that entry's most recent outcomes;
- sixteen 2-bit saturating counters.

The record, read as a binary number, picks the counter that votes. Because of this, a branch that follows a short repeating pattern gets one trained counter for each position of the pattern. The block handles direction only. Target addresses, speculative history repair and the pipeline around it belong elsewhere.

The three streams follow these rules.
- Lookup and response follow valid/ready. A lookup is accepted on a rising edge where `lk_valid` and `lk_ready` are both high. Its prediction sits in a single output register. `lk_ready` is high whenever that register is empty or is being drained in the same cycle, so back-pressure on `pr_ready` stalls new lookups without losing the pending one.
- The resolve stream is never back-pressured: `rs_ready` is always high.
- Reset is synchronous and active high.

Top module: `lhp_predictor`

## Requirements
- R1: After reset, `pr_valid` is 0. Every history is 0 and every counter is 1, so the first lookup of any address predicts not taken (`pr_taken` = 0).
- R2: The entry index is address bits [10:2] (index width = log2 of 512 entries, two alignment bits dropped). Address bits below bit 2 and above bit 10 are ignored, and no tag is checked, so addresses equal in bits [10:2] share one entry.
- R3: A prediction is taken (`pr_taken` = 1) exactly when the counter chosen by the entry's 4-bit history, taken as an index 0..15, holds 2 or 3.
- R4: On a resolve, only the counter chosen by the history held before the update changes. It steps up by one on taken and down by one on not taken, and it saturates at 3 and at 0.
- R5: After the counter update, the history shifts one place toward its most significant bit. The oldest bit is dropped and the new outcome (1 = taken) enters bit 0.
- R6: A lookup accepted on a rising edge makes `pr_valid` high and `pr_taken` valid right after that edge.
- R7: While `pr_valid` is high and `pr_ready` is low, `pr_taken` holds its value, `pr_valid` stays high and `lk_ready` is low.
- R8: `rs_ready` is high out of reset. A resolve accepted on an edge affects lookups accepted on later edges. A lookup accepted on the same edge as a resolve to the same entry sees the state from before that resolve.
- R9: A branch whose outcomes repeat with a period of five or fewer is predicted correctly on every occurrence from the fifth repetition of its pattern onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_pc | input | 32 | Branch address to predict |
| pr_valid | output | 1 | Prediction valid |
| pr_ready | input | 1 | Consumer accepts the prediction |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| rs_valid | input | 1 | Resolved outcome valid |
| rs_ready | output | 1 | Resolve can be accepted (always high) |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A prediction is due one cycle after the edge that accepts its lookup. A resolve trains the table on its accepting edge, so a lookup accepted on the next edge already sees the new state, while a lookup on the same edge sees the old state.

The bench changes its inputs one nanosecond after each rising edge and samples at the falling edge. A scoreboard entry is pushed at the falling edge just before the accepting edge, from a reference table updated in the same order as R4 and R5. The monitor pops it at the falling edge where `pr_valid` and `pr_ready` are both high, so each comparison falls exactly in the cycle the prediction leaves the block. This holds through stalls as well.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  localparam int unsigned CTR_W = 2;

  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_MAX       = '1;
  localparam ctr_t CTR_INIT      = ctr_t'((1 << (CTR_W - 1)) - 1);
  localparam ctr_t CTR_TAKEN_MIN = ctr_t'(1 << (CTR_W - 1));

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    return (c == '0) ? c : c - ctr_t'(1);
  endfunction

  function automatic logic ctr_votes_taken(ctr_t c);
    return c >= CTR_TAKEN_MIN;
  endfunction

endpackage

// File: rtl/lhp_index.sv
module lhp_index #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ALIGN_W = 2,
  parameter int unsigned IDX_W   = 9
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  // R2: alignment bits and upper bits take no part in the index
  assign idx = pc[ALIGN_W +: IDX_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^pc;
endmodule

// File: rtl/lhp_select.sv
module lhp_select import lhp_pkg::*; #(
  parameter int unsigned HIST_W = 4,
  localparam int unsigned NCTR  = 1 << HIST_W
) (
  input  logic [HIST_W-1:0]  hist,
  input  ctr_t [NCTR-1:0]    ctrs,
  output logic               taken
);
  // R3: the history value picks the voting counter
  assign taken = ctr_votes_taken(ctrs[hist]);
endmodule

// File: rtl/lhp_update.sv
module lhp_update import lhp_pkg::*; #(
  parameter int unsigned HIST_W = 4,
  localparam int unsigned NCTR  = 1 << HIST_W
) (
  input  logic               active,
  input  logic               taken,
  input  logic [HIST_W-1:0]  hist,
  input  ctr_t [NCTR-1:0]    ctrs,
  output logic [HIST_W-1:0]  hist_nxt,
  output ctr_t [NCTR-1:0]    ctrs_nxt
);
  logic [NCTR-1:0] lane_moved;

  // R4: only the lane named by the old history steps
  for (genvar i = 0; i < NCTR; i++) begin : g_lane
    assign ctrs_nxt[i]   = (hist == HIST_W'(i)) ? ctr_step(ctrs[i], taken) : ctrs[i];
    assign lane_moved[i] = (ctrs_nxt[i] != ctrs[i]);
  end

  // R5: newest outcome enters bit 0
  if (HIST_W == 1) begin : g_hist_one
    assign hist_nxt = taken;
  end else begin : g_hist_shift
    assign hist_nxt = {hist[HIST_W-2:0], taken};
  end

  always_comb begin
    if (active) begin
      p_one_lane_r4: assert ($countones(lane_moved) <= 1)
        else $error("more than one counter changed");
      if (taken) begin
        p_no_drop_r4: assert (ctrs_nxt[hist] >= ctrs[hist])
          else $error("taken outcome lowered a counter");
      end else begin
        p_no_rise_r4: assert (ctrs_nxt[hist] <= ctrs[hist])
          else $error("not-taken outcome raised a counter");
      end
    end
  end
endmodule

// File: rtl/lhp_table.sv
module lhp_table import lhp_pkg::*; #(
  parameter int unsigned ENTRIES = 512,
  parameter int unsigned HIST_W  = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned NCTR   = 1 << HIST_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   rda_idx,
  output logic [HIST_W-1:0]  rda_hist,
  output ctr_t [NCTR-1:0]    rda_ctrs,
  input  logic [IDX_W-1:0]   rdb_idx,
  output logic [HIST_W-1:0]  rdb_hist,
  output ctr_t [NCTR-1:0]    rdb_ctrs,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [HIST_W-1:0]  wr_hist,
  input  ctr_t [NCTR-1:0]    wr_ctrs
);
  logic [HIST_W-1:0] hist_q [ENTRIES];
  ctr_t [NCTR-1:0]   ctr_q  [ENTRIES];

  // R8: both ports read the state held before this edge
  assign rda_hist = hist_q[rda_idx];
  assign rda_ctrs = ctr_q[rda_idx];
  assign rdb_hist = hist_q[rdb_idx];
  assign rdb_ctrs = ctr_q[rdb_idx];

  // R1: clear histories, counters to weakly not taken
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        hist_q[e] <= '0;
        ctr_q[e]  <= {NCTR{CTR_INIT}};
      end
    end else if (wr_en) begin
      hist_q[wr_idx] <= wr_hist;
      ctr_q[wr_idx]  <= wr_ctrs;
    end
  end
endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor import lhp_pkg::*; #(
  parameter int unsigned ENTRIES = 512,
  parameter int unsigned HIST_W  = 4,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pr_valid,
  input  logic            pr_ready,
  output logic            pr_taken,
  input  logic            rs_valid,
  output logic            rs_ready,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned NCTR  = 1 << HIST_W;

  logic              lk_fire, rs_fire;
  logic [IDX_W-1:0]  lk_idx, rs_idx;
  logic [HIST_W-1:0] lk_hist, rs_hist, rs_hist_nxt;
  ctr_t [NCTR-1:0]   lk_ctrs, rs_ctrs, rs_ctrs_nxt;
  logic              lk_taken;

  // R7: one output slot, refilled when empty or draining
  assign lk_ready = !pr_valid || pr_ready;
  assign rs_ready = 1'b1;
  assign lk_fire  = lk_valid && lk_ready;
  assign rs_fire  = rs_valid && rs_ready;

  lhp_index #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_lk_index (
    .pc(lk_pc), .idx(lk_idx)
  );

  lhp_index #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_rs_index (
    .pc(rs_pc), .idx(rs_idx)
  );

  lhp_table #(.ENTRIES(ENTRIES), .HIST_W(HIST_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rda_idx  (lk_idx),
    .rda_hist (lk_hist),
    .rda_ctrs (lk_ctrs),
    .rdb_idx  (rs_idx),
    .rdb_hist (rs_hist),
    .rdb_ctrs (rs_ctrs),
    .wr_en    (rs_fire),
    .wr_idx   (rs_idx),
    .wr_hist  (rs_hist_nxt),
    .wr_ctrs  (rs_ctrs_nxt)
  );

  lhp_select #(.HIST_W(HIST_W)) u_select (
    .hist  (lk_hist),
    .ctrs  (lk_ctrs),
    .taken (lk_taken)
  );

  lhp_update #(.HIST_W(HIST_W)) u_update (
    .active   (rs_fire),
    .taken    (rs_taken),
    .hist     (rs_hist),
    .ctrs     (rs_ctrs),
    .hist_nxt (rs_hist_nxt),
    .ctrs_nxt (rs_ctrs_nxt)
  );

  // R6: prediction registered on the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid <= 1'b0;
      pr_taken <= 1'b0;
    end else if (lk_fire) begin
      pr_valid <= 1'b1;
      pr_taken <= lk_taken;
    end else if (pr_ready) begin
      pr_valid <= 1'b0;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !pr_valid)
    else $error("response valid right after reset");

  p_accept_gives_valid_r6: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_ready |=> pr_valid)
    else $error("accepted lookup produced no response");

  p_hold_while_stalled_r7: assert property (@(posedge clk) disable iff (rst)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_taken))
    else $error("stalled response changed");
endmodule

// File: tb/lhp_predictor_bench.sv
module lhp_predictor_bench;
  localparam int ENTRIES = 512;
  localparam int NCTR    = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_ready;
  logic [31:0] lk_pc = '0;
  logic        pr_valid, pr_ready = 1'b1, pr_taken;
  logic        rs_valid = 1'b0, rs_ready;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;

  always #2 clk = ~clk;

  lhp_predictor u_lhp_predictor (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_taken(pr_taken),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc), .rs_taken(rs_taken)
  );

  int    checks = 0;
  int    bad    = 0;
  bit    exp_q[$];
  string req_q[$];
  int    m_hist [ENTRIES];
  int    m_ctr  [ENTRIES][NCTR];

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // R2: index from bits [10:2]
  function automatic int m_idx(logic [31:0] pc);
    return int'(pc[10:2]);
  endfunction

  function automatic bit m_pred(logic [31:0] pc);
    int e = m_idx(pc);
    return m_ctr[e][m_hist[e]] >= 2;
  endfunction

  task automatic m_train(logic [31:0] pc, bit t);
    int e = m_idx(pc);
    int h = m_hist[e];
    if (t && m_ctr[e][h] < 3) m_ctr[e][h]++;
    if (!t && m_ctr[e][h] > 0) m_ctr[e][h]--;
    m_hist[e] = ((h << 1) | int'(t)) & 15;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pr_valid && pr_ready) begin
      if (exp_q.size() == 0) begin
        chk("R6", 1'b1, 1'b0, "unexpected response");
      end else begin
        chk(req_q.pop_front(), pr_taken, exp_q.pop_front(), "prediction");
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic lookup(logic [31:0] pc, string req, bit use_lit, bit lit);
    lk_valid = 1'b1;
    lk_pc    = pc;
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    exp_q.push_back(use_lit ? lit : m_pred(pc));
    req_q.push_back(req);
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
    chk("R6", pr_valid, 1'b1, "valid after accept");
  endtask

  task automatic resolve(logic [31:0] pc, bit t);
    rs_valid = 1'b1;
    rs_pc    = pc;
    rs_taken = t;
    @(posedge clk);
    #1;
    rs_valid = 1'b0;
    m_train(pc, t);
  endtask

  task automatic lookup_and_resolve(logic [31:0] pc, bit t, string req);
    lk_valid = 1'b1; lk_pc = pc;
    rs_valid = 1'b1; rs_pc = pc; rs_taken = t;
    @(negedge clk);
    exp_q.push_back(m_pred(pc));
    req_q.push_back(req);
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
    rs_valid = 1'b0;
    m_train(pc, t);
  endtask

  task automatic run_pattern(logic [31:0] pc, int len, logic [4:0] pat);
    for (int rep = 0; rep < 8; rep++) begin
      for (int k = 0; k < len; k++) begin
        if (rep >= 4) lookup(pc, "R9", 1'b1, pat[k]);
        else lookup(pc, "R3", 1'b0, 1'b0);
        resolve(pc, pat[k]);
      end
    end
  endtask

  task automatic run_all();
    localparam logic [31:0] A = 32'h0000_0100;
    for (int e = 0; e < ENTRIES; e++) begin
      m_hist[e] = 0;
      for (int c = 0; c < NCTR; c++) m_ctr[e][c] = 1;
    end
    idle(3);
    rst = 1'b0;
    chk("R1", pr_valid, 1'b0, "valid after reset");
    chk("R7", lk_ready, 1'b1, "lookup ready after reset");
    chk("R8", rs_ready, 1'b1, "resolve ready after reset");

    // R1: fresh entries predict not taken
    lookup(32'h0000_0040, "R1", 1'b1, 1'b0);
    lookup(32'h0000_1FFC, "R1", 1'b1, 1'b0);

    // R2: aliasing and ignored low bits
    for (int i = 0; i < 6; i++) resolve(A, 1'b1);
    lookup(A, "R2", 1'b1, 1'b1);
    lookup(A + 32'h800, "R2", 1'b1, 1'b1);
    lookup(A + 32'h3, "R2", 1'b1, 1'b1);
    lookup(A + 32'h4, "R2", 1'b1, 1'b0);

    // R9 / R5: repeating patterns, lowest bit first
    run_pattern(32'h0000_0200, 5, 5'b01011);
    run_pattern(32'h0000_0240, 3, 5'b00001);

    // R4: saturation at the top
    for (int i = 0; i < 9; i++) resolve(32'h0000_0400, 1'b1);
    resolve(32'h0000_0400, 1'b0);
    for (int i = 0; i < 4; i++) resolve(32'h0000_0400, 1'b1);
    lookup(32'h0000_0400, "R4", 1'b1, 1'b1);

    // R4: saturation at the bottom
    for (int i = 0; i < 4; i++) resolve(32'h0000_0480, 1'b0);
    lookup(32'h0000_0480, "R4", 1'b1, 1'b0);

    // R8: same-edge lookup sees the old state
    resolve(32'h0000_0600, 1'b1);
    for (int i = 0; i < 4; i++) resolve(32'h0000_0600, 1'b0);
    lookup_and_resolve(32'h0000_0600, 1'b0, "R8");
    lookup(32'h0000_0600, "R8", 1'b1, 1'b0);

    // R7: back-pressure
    idle(2);
    pr_ready = 1'b0;
    lookup(A, "R7", 1'b0, 1'b0);
    lk_valid = 1'b1;
    lk_pc    = A + 32'h4;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7", lk_ready, 1'b0, "ready while stalled");
      chk("R7", pr_valid, 1'b1, "valid while stalled");
      chk("R7", pr_taken, m_pred(A), "held prediction");
    end
    @(posedge clk);
    #1;
    pr_ready = 1'b1;
    @(negedge clk);
    chk("R7", lk_ready, 1'b1, "ready when draining");
    exp_q.push_back(m_pred(A + 32'h4));
    req_q.push_back("R7");
    @(posedge clk);
    #1;
    lk_valid = 1'b0;

    idle(4);
    chk("R6", exp_q.size() == 0, 1'b1, "all responses delivered");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R6 watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule